// File: doc/BRIEF.md
# Protection Region Permission Mapper

This block decides, for one address at a time, what a processor may do there. Eight programmable windows describe the address space. Each window has a control word that holds its enable, its size and its base. It also has a 4-bit access code for data accesses, a 4-bit access code for instruction fetches, and three cache-policy bits. A lookup port takes an address and a privilege flag and returns a 7-bit attribute vector in the same cycle. Software programs the windows through a single-cycle register write port.

When several enabled windows cover the same address, the window with the highest index wins and supplies the whole attribute vector. A global control register can switch the whole unit off. The unit then opens every address for read, write and execute, and the cache attributes follow only the global cache enables. Cache control and fault reporting sit in neighbouring blocks, which consume the attribute vector.

Top module: `prot_region_mapper`

## Requirements
- R1: After reset every register holds zero, so the unit is off and any lookup returns 0x07 (read, write and execute, no cache attributes).
- R2: When control bit 0 is clear, attribute bits 2:0 are all set in both modes. Bits 4 and 5 both equal control bit 2 (the data-cache enable), and bit 6 equals control bit 12 (the instruction-cache enable).
- R3: Window word bit 0 enables the window. Bits 5:1 give a size code c, and the span is 2^(c+1) bytes, with codes below 5 treated as 5 (64 bytes). An address hits when its bits above the span match the same bits of the window word. A window whose enable bit is clear takes no part in lookups.
- R4: Window n takes its data access code from bits 4n+3:4n of the data permission word. Codes 1 and 2 give privileged read and write, and code 2 adds user read. Code 3 gives read and write to both modes, code 5 gives privileged read only, and code 6 gives read to both modes. Every other code gives nothing.
- R5: Window n takes its execute code from bits 4n+3:4n of the code permission word. Codes 1, 2, 3, 5 and 6 grant privileged execute. Codes 2, 3 and 6 also grant user execute.
- R6: When several enabled windows hit, the window with the highest index supplies the whole attribute vector.
- R7: With the unit on and no enabled window hit, the attribute vector is 0x00.
- R8: For the hitting window n, bit 4 = data-cacheable bit n AND control bit 2. Bit 5 = bit 4 AND write-back bit n. Bit 6 = instruction-cacheable bit n AND control bit 12.
- R9: A write with wr_en high updates the selected register at the clock edge, and lookups reflect it from the next cycle. The select codes are: 0 control, 1 data permissions, 2 code permissions, 3 data-cacheable bits, 4 write-back bits, 5 instruction-cacheable bits, and 8+n window n. Codes 6 and 7 change nothing.
- R10: lk_priv high returns the privileged view, and low returns the user view. The attribute encoding is bit 0 read, bit 1 write, bit 2 execute, bit 3 always zero, bit 4 data-cacheable, bit 5 write-back and bit 6 instruction-cacheable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 32 | Register write data |
| lk_addr | input | 32 | Lookup address |
| lk_priv | input | 1 | 1 = privileged view, 0 = user view |
| lk_attr | output | 7 | Attribute vector for lk_addr |

## Verification
Several properties are checked on every cycle. The user rights never exceed the privileged rights, and write-back never appears without data-cacheable. The cache attributes stay silent while their global enables are off. A disabled unit always opens read, write and execute. An enabled unit with no hit denies everything. At most one window wins, and control writes land on the next edge. Only the bench's scenarios can show the rest: the decoding of each access code and its packing position, the span arithmetic at window edges and the 64-byte floor, the override order between overlapping windows, and that the unused select codes leave all state alone.

// File: rtl/prm_pkg.sv
package prm_pkg;
  localparam int ADDR_W    = 32;
  localparam int CODE_W    = 4;
  localparam int ATTR_W    = 7;
  localparam int MIN_SHIFT = 6;

  typedef logic [ATTR_W-1:0] attr_t;

  // Select codes for the non-window registers
  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_DPERM = 3'd1;
  localparam logic [2:0] SEL_CPERM = 3'd2;
  localparam logic [2:0] SEL_DCB   = 3'd3;
  localparam logic [2:0] SEL_WBB   = 3'd4;
  localparam logic [2:0] SEL_ICB   = 3'd5;

  function automatic logic can_read(input logic [CODE_W-1:0] c, input logic priv);
    case (c)
      4'd1:    return priv;
      4'd2:    return 1'b1;
      4'd3:    return 1'b1;
      4'd5:    return priv;
      4'd6:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic can_write(input logic [CODE_W-1:0] c, input logic priv);
    case (c)
      4'd1, 4'd2: return priv;
      4'd3:       return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

  // Span is 2^(code+1) bytes, floored at 2^MIN_SHIFT
  function automatic logic region_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] rgn);
    logic [5:0]        sh;
    logic [ADDR_W-1:0] keep;
    sh   = (rgn[5:1] < 5'(MIN_SHIFT-1)) ? 6'(MIN_SHIFT) : ({1'b0, rgn[5:1]} + 6'd1);
    keep = (sh >= 6'(ADDR_W)) ? '0 : ~((ADDR_W'(1) << sh) - ADDR_W'(1));
    return ((a ^ rgn) & keep) == '0;
  endfunction

  function automatic attr_t pack_attr(input logic r, input logic w, input logic x,
                                      input logic dc, input logic wb, input logic ic);
    return {ic, wb, dc, 1'b0, x, w, r};
  endfunction
endpackage

// File: rtl/prm_regfile.sv
module prm_regfile
  import prm_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int SEL_W       = 4,
  parameter int IDX_W       = 3,
  parameter int PW          = NUM_REGIONS * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              unit_en,
  output logic              dce,
  output logic              ice,
  output logic [PW-1:0]     dperm,
  output logic [PW-1:0]     cperm,
  output logic [NUM_REGIONS-1:0] dcb,
  output logic [NUM_REGIONS-1:0] wbb,
  output logic [NUM_REGIONS-1:0] icb,
  output logic [ADDR_W-1:0] rgn_q [NUM_REGIONS]
);
  logic is_win;
  assign is_win = wr_sel[SEL_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit_en <= 1'b0;
      dce     <= 1'b0;
      ice     <= 1'b0;
      dperm   <= '0;
      cperm   <= '0;
      dcb     <= '0;
      wbb     <= '0;
      icb     <= '0;
    end else if (wr_en && !is_win) begin
      case (wr_sel[2:0])
        SEL_CTRL: begin
          unit_en <= wr_data[0];
          dce     <= wr_data[2];
          ice     <= wr_data[12];
        end
        SEL_DPERM: dperm <= wr_data[PW-1:0];
        SEL_CPERM: cperm <= wr_data[PW-1:0];
        SEL_DCB:   dcb   <= wr_data[NUM_REGIONS-1:0];
        SEL_WBB:   wbb   <= wr_data[NUM_REGIONS-1:0];
        SEL_ICB:   icb   <= wr_data[NUM_REGIONS-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n)
        rgn_q[g] <= '0;
      else if (wr_en && is_win && wr_sel[IDX_W-1:0] == IDX_W'(g))
        rgn_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/prm_region_eval.sv
module prm_region_eval
  import prm_pkg::*;
(
  input  logic [ADDR_W-1:0] rgn,
  input  logic [CODE_W-1:0] dcode,
  input  logic [CODE_W-1:0] ccode,
  input  logic              dc_bit,
  input  logic              wb_bit,
  input  logic              ic_bit,
  input  logic              dce,
  input  logic              ice,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output attr_t             attr_p,
  output attr_t             attr_u
);
  logic dc, wb, ic;
  assign hit    = rgn[0] & region_hit(addr, rgn);
  assign dc     = dc_bit & dce;
  assign wb     = dc & wb_bit;
  assign ic     = ic_bit & ice;
  assign attr_p = pack_attr(can_read(dcode, 1'b1), can_write(dcode, 1'b1),
                            can_read(ccode, 1'b1), dc, wb, ic);
  assign attr_u = pack_attr(can_read(dcode, 1'b0), can_write(dcode, 1'b0),
                            can_read(ccode, 1'b0), dc, wb, ic);
endmodule

// File: rtl/prm_prio.sv
module prm_prio #(
  parameter int NUM_REGIONS = 8
) (
  input  logic [NUM_REGIONS-1:0] hit,
  output logic [NUM_REGIONS-1:0] win,
  output logic                   any_hit
);
  // Later index overwrites earlier: highest index wins
  always_comb begin
    win     = '0;
    any_hit = 1'b0;
    for (int n = 0; n < NUM_REGIONS; n++) begin
      if (hit[n]) begin
        win    = '0;
        win[n] = 1'b1;
        any_hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prot_region_mapper.sv
module prot_region_mapper
  import prm_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [31:0] lk_addr,
  input  logic        lk_priv,
  output logic [6:0]  lk_attr
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int SEL_W = 4;
  localparam int PW    = NUM_REGIONS * CODE_W;

  logic              unit_en, dce, ice;
  logic [PW-1:0]     dperm, cperm;
  logic [NUM_REGIONS-1:0] dcb, wbb, icb;
  logic [ADDR_W-1:0] rgn_q [NUM_REGIONS];

  logic [NUM_REGIONS-1:0] hit_vec, win_vec;
  logic                   any_hit;
  attr_t attr_p_arr [NUM_REGIONS];
  attr_t attr_u_arr [NUM_REGIONS];
  attr_t sel_p, sel_u, open_attr, attr_priv, attr_user;

  prm_regfile #(
    .NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W), .IDX_W(IDX_W), .PW(PW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .unit_en(unit_en), .dce(dce), .ice(ice), .dperm(dperm), .cperm(cperm),
    .dcb(dcb), .wbb(wbb), .icb(icb), .rgn_q(rgn_q)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_eval
    prm_region_eval u_eval (
      .rgn(rgn_q[g]),
      .dcode(dperm[g*CODE_W +: CODE_W]),
      .ccode(cperm[g*CODE_W +: CODE_W]),
      .dc_bit(dcb[g]), .wb_bit(wbb[g]), .ic_bit(icb[g]),
      .dce(dce), .ice(ice), .addr(lk_addr),
      .hit(hit_vec[g]), .attr_p(attr_p_arr[g]), .attr_u(attr_u_arr[g])
    );
  end

  prm_prio #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
    .hit(hit_vec), .win(win_vec), .any_hit(any_hit)
  );

  always_comb begin
    sel_p = '0;
    sel_u = '0;
    for (int n = 0; n < NUM_REGIONS; n++) begin
      sel_p = sel_p | (attr_p_arr[n] & {ATTR_W{win_vec[n]}});
      sel_u = sel_u | (attr_u_arr[n] & {ATTR_W{win_vec[n]}});
    end
  end

  assign open_attr = pack_attr(1'b1, 1'b1, 1'b1, dce, dce, ice);
  assign attr_priv = !unit_en ? open_attr : (any_hit ? sel_p : '0);
  assign attr_user = !unit_en ? open_attr : (any_hit ? sel_u : '0);
  assign lk_attr   = lk_priv ? attr_priv : attr_user;
endmodule

// File: rtl/prot_region_mapper_chk.sv
module prot_region_mapper_chk #(
  parameter int NUM_REGIONS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [3:0]             wr_sel,
  input logic [2:0]             ctl_bits,
  input logic                   unit_en,
  input logic                   dce,
  input logic                   ice,
  input logic                   any_hit,
  input logic [NUM_REGIONS-1:0] win_vec,
  input logic [5:0]             ap,
  input logic [5:0]             au
);
  // ap/au: {ic, wb, dc, x, w, r}
  AST_WB_NEEDS_DC: assert property (@(posedge clk) disable iff (!rst_n)
    (ap[4] -> ap[3]) && (au[4] -> au[3])); // R8
  AST_DC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dce |-> !ap[3] && !au[3]); // R8
  AST_IC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ice |-> !ap[5] && !au[5]); // R8
  AST_OFF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |-> ap[2:0] == 3'b111 && au[2:0] == 3'b111); // R2
  AST_NO_HIT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    unit_en && !any_hit |-> ap == '0 && au == '0); // R7
  AST_USER_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (au[2:0] & ~ap[2:0]) == 3'b000); // R4
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec)); // R6
  AST_CTRL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 4'd0 |=> {ice, dce, unit_en} == $past(ctl_bits)); // R9
endmodule

bind prot_region_mapper prot_region_mapper_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .ctl_bits({wr_data[12], wr_data[2], wr_data[0]}),
  .unit_en(unit_en), .dce(dce), .ice(ice), .any_hit(any_hit), .win_vec(win_vec),
  .ap({attr_priv[6:4], attr_priv[2:0]}),
  .au({attr_user[6:4], attr_user[2:0]})
);

// File: tb/prot_region_mapper_bench.sv
`timescale 1ns/1ps
module prot_region_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] lk_addr = '0;
  logic        lk_priv = 1'b0;
  logic [6:0]  lk_attr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  prot_region_mapper u_prot_region_mapper (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lk_addr(lk_addr), .lk_priv(lk_priv), .lk_attr(lk_attr)
  );

  // Behavioural reference state
  logic [31:0] m_ctrl, m_dp, m_cp, m_dcb, m_wbb, m_icb;
  logic [31:0] m_rg [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_dp = 0; m_cp = 0; m_dcb = 0; m_wbb = 0; m_icb = 0;
      for (int i = 0; i < 8; i++) m_rg[i] = 0;
    end else if (wr_en) begin
      if (wr_sel >= 8) m_rg[wr_sel - 8] = wr_data;
      else if (wr_sel == 0) m_ctrl = wr_data;
      else if (wr_sel == 1) m_dp = wr_data;
      else if (wr_sel == 2) m_cp = wr_data;
      else if (wr_sel == 3) m_dcb = wr_data;
      else if (wr_sel == 4) m_wbb = wr_data;
      else if (wr_sel == 5) m_icb = wr_data;
    end
  end

  function automatic logic [6:0] ref_attr(input logic [31:0] a, input logic p);
    logic dce, ice;
    int   code, sh, dc, cc;
    logic r, w, x, c_d, c_w, c_i;
    dce = m_ctrl[2];
    ice = m_ctrl[12];
    if (!m_ctrl[0]) return {ice, dce, dce, 1'b0, 3'b111};
    for (int n = 7; n >= 0; n--) begin
      if (m_rg[n][0]) begin
        code = int'(m_rg[n][5:1]);
        if (code < 5) code = 5;
        sh = code + 1;
        if (sh >= 32 || (a >> sh) == (m_rg[n] >> sh)) begin
          dc = int'((m_dp >> (4*n)) & 32'hF);
          cc = int'((m_cp >> (4*n)) & 32'hF);
          if (p) begin
            r = dc inside {1, 2, 3, 5, 6};
            w = dc inside {1, 2, 3};
            x = cc inside {1, 2, 3, 5, 6};
          end else begin
            r = dc inside {2, 3, 6};
            w = (dc == 3);
            x = cc inside {2, 3, 6};
          end
          c_d = m_dcb[n] && dce;
          c_w = c_d && m_wbb[n];
          c_i = m_icb[n] && ice;
          return {c_i, c_w, c_d, 1'b0, x, w, r};
        end
      end
    end
    return 7'h00;
  endfunction

  // Comparison against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (lk_attr !== ref_attr(lk_addr, lk_priv)) begin
        n_fail++;
        $display("FAIL R10 model compare addr=%h priv=%0d actual=%h expected=%h",
                 lk_addr, lk_priv, lk_attr, ref_attr(lk_addr, lk_priv));
      end
    end
  end

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic p, input logic [6:0] exp,
                      input string tag);
    lk_addr = a; lk_priv = p;
    @(negedge clk);
    n_tests++;
    if (lk_attr !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h priv=%0d actual=%h expected=%h", tag, a, p, lk_attr, exp);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    look(32'h0000_1234, 1'b0, 7'h07, "R1");
    look(32'hFFFF_FFF0, 1'b1, 7'h07, "R1");
    // R2 unit off follows global cache enables
    wr(4'd0, 32'h0000_1004); look(32'h1000_0000, 1'b0, 7'h77, "R2");
    wr(4'd0, 32'h0000_0004); look(32'h1000_0000, 1'b1, 7'h37, "R2");
    wr(4'd0, 32'h0000_1000); look(32'h1000_0000, 1'b0, 7'h47, "R2");
    // R7 unit on, nothing mapped
    wr(4'd0, 32'h0000_0001); look(32'h1000_0000, 1'b1, 7'h00, "R7");
    // Background window 0 over everything
    wr(4'd8, 32'h0000_003F); wr(4'd1, 32'h3); wr(4'd2, 32'h6);
    look(32'h1000_0000, 1'b0, 7'h07, "R4");
    look(32'h1000_0000, 1'b1, 7'h07, "R5");
    // Window 2: 16 KB at 0x4000_0000, codes 5/5
    wr(4'd10, 32'h4000_001B); wr(4'd1, 32'h503); wr(4'd2, 32'h506);
    look(32'h4000_1000, 1'b1, 7'h05, "R4");
    look(32'h4000_1000, 1'b0, 7'h00, "R10");
    look(32'h4000_3FFC, 1'b0, 7'h00, "R3");
    look(32'h4000_4000, 1'b0, 7'h07, "R3");
    look(32'h3FFF_FFFC, 1'b0, 7'h07, "R6");
    // Other data codes
    wr(4'd1, 32'h203); look(32'h4000_1000, 1'b1, 7'h07, "R4"); look(32'h4000_1000, 1'b0, 7'h01, "R4");
    wr(4'd1, 32'h103); look(32'h4000_1000, 1'b1, 7'h07, "R4"); look(32'h4000_1000, 1'b0, 7'h00, "R4");
    wr(4'd1, 32'h003); look(32'h4000_1000, 1'b1, 7'h04, "R4");
    wr(4'd1, 32'h903); look(32'h4000_1000, 1'b1, 7'h04, "R4"); look(32'h4000_1000, 1'b0, 7'h00, "R4");
    // Code-word execute codes
    wr(4'd1, 32'h603);
    wr(4'd2, 32'h306); look(32'h4000_1000, 1'b0, 7'h05, "R5");
    wr(4'd2, 32'h106); look(32'h4000_1000, 1'b1, 7'h05, "R5"); look(32'h4000_1000, 1'b0, 7'h01, "R5");
    wr(4'd2, 32'h206); look(32'h4000_1000, 1'b0, 7'h05, "R5");
    // R8 cache attributes
    wr(4'd0, 32'h0000_1005); wr(4'd3, 32'h04); wr(4'd4, 32'h04); wr(4'd7, 32'h0); wr(4'd5, 32'h04);
    look(32'h4000_1000, 1'b1, 7'h75, "R8");
    look(32'h0000_0100, 1'b1, 7'h07, "R8");
    wr(4'd3, 32'h00); look(32'h4000_1000, 1'b1, 7'h45, "R8");
    wr(4'd3, 32'h04); wr(4'd0, 32'h0000_0005); look(32'h4000_1000, 1'b0, 7'h35, "R8");
    wr(4'd0, 32'h0000_1001); look(32'h4000_1000, 1'b0, 7'h45, "R8");
    // R3 disabled window falls through
    wr(4'd0, 32'h0000_0001);
    wr(4'd10, 32'h4000_001A); look(32'h4000_1000, 1'b1, 7'h07, "R3");
    // R3 64-byte floor, window 3 code 1
    wr(4'd11, 32'h8000_0041); wr(4'd1, 32'h1003); wr(4'd2, 32'h0006);
    look(32'h8000_007C, 1'b0, 7'h00, "R3");
    look(32'h8000_007C, 1'b1, 7'h03, "R3");
    look(32'h8000_0040, 1'b1, 7'h03, "R3");
    look(32'h8000_0080, 1'b1, 7'h07, "R3");
    look(32'h8000_003C, 1'b1, 7'h07, "R3");
    // R6 window 5 (256 MB, code 6) overrides window 3
    wr(4'd13, 32'h8000_0037); wr(4'd1, 32'h0060_1003); wr(4'd5, 32'h20);
    look(32'h8000_0040, 1'b1, 7'h01, "R6");
    look(32'h9000_0000, 1'b1, 7'h07, "R6");
    // R9 unused select codes change nothing
    wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    look(32'h8000_0040, 1'b1, 7'h01, "R9");
    look(32'h8000_0040, 1'b0, 7'h01, "R9");
    look(32'h4000_1000, 1'b0, 7'h07, "R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule